// File: doc/BRIEF.md
# Oversampled NRZ Character Receiver

This block turns a clockless, asynchronous NRZ bit stream into bytes. A free-running sample clock runs at a fixed multiple of the bit rate, set by the parameter `OSR` (32 by default). The block waits for a high-to-low edge on the line. It takes that edge as the start of a character and steps through the bit cells by counting samples. Each bit value comes from a majority vote over the centre half of its cell. The receiver drops back to edge hunting as soon as the stop bit has been voted. Each character therefore starts from its own edge, and timing error does not build up from one character to the next.

Each byte that frames correctly is shown for one cycle with a valid strobe. It is also fed into a CRC-16 accumulator. An end-of-frame strobe from the surrounding logic closes the frame. At that strobe the block reports whether the bytes received since the previous strobe, including the two trailing check bytes, leave the expected residue. The analog front end and the comparator sit outside this block. The line input is taken as already synchronous to the sample clock.

Top module: `nrz_char_rx`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `byte_valid`, `framing_error` and `crc_ok` are 0.
- R2: A character is a low start bit, `DATA_W` data bits sent LSB first, and a high stop bit, each lasting `OSR` samples. Count sample 0 as the first low sample after a high one. `byte_valid` is high for exactly one cycle, with `byte_data` holding the byte, in the cycle after sample 9*OSR + 3*OSR/4 - 1.
- R3: Each bit is decided only from the samples at cell positions OSR/4 through 3*OSR/4-1: the value held by more than half of them wins. Samples outside that window have no effect on the result.
- R4: When exactly half of the window samples are 1, the bit takes the value of the bit decided before it. For data bit 0, that earlier bit is the start bit, which is 0.
- R5: If the start bit votes high, no output is produced and the receiver goes back to looking for a falling edge.
- R6: If the stop bit votes low, `framing_error` pulses for one cycle, `byte_valid` stays low, and the byte is left out of the CRC.
- R7: Bit timing restarts at the first falling edge after each stop-bit vote. A sender whose data bits drift by up to OSR/4 samples within a character is still received correctly, including characters sent back to back with no idle gap.
- R8: The CRC accumulator starts at 0xFFFF. It shifts each accepted byte LSB first using the reflected form of polynomial 0x1021 (0x8408). A frame is good when, after the payload and the inverted CRC (low byte first), the accumulator equals 0xF0B8.
- R9: `crc_ok` changes only in the cycle after `frame_end` is high, and then holds until the next `frame_end`. The accumulator restarts at 0xFFFF after every `frame_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, OSR times the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 1 | Comparator output, NRZ data |
| frame_end | input | 1 | One-cycle strobe that closes a frame |
| byte_valid | output | 1 | One-cycle strobe for a correctly framed byte |
| byte_data | output | DATA_W | Received byte, valid with `byte_valid` |
| framing_error | output | 1 | One-cycle strobe when a stop bit votes low |
| crc_ok | output | 1 | Result of the CRC check at the last `frame_end` |

## Verification
The bench builds the receiver with `OSR` = 16 and `DATA_W` = 8. This gives a vote window of eight samples, at cell positions 4 to 11, and a drift margin of four samples. These small numbers let the bench craft exact ties, minority glitches inside the window, and full corruption outside it sample by sample. They also make it practical to stretch or shrink four data bits by one sample each, which reaches the full quarter-bit drift in both directions at the tightest back-to-back spacing. A short cell also keeps each CRC frame to a few hundred cycles, so good, corrupted and framing-error frames all fit in one run.

// File: rtl/nrzrx_pkg.sv
// Shared types for the NRZ character receiver.
package nrzrx_pkg;
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/nrz_bit_voter.sv
// Majority voter for one bit cell.
// Counts the ones seen at cell positions WIN_LO..WIN_HI-1. bit_val is the
// decision that includes the current sample; it is meaningful at WIN_HI-1.
// A tie returns prev_bit. Assumes OSR >= 4, so position 0 is outside the window.
module nrz_bit_voter #(
    parameter int OSR = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic [$clog2(OSR)-1:0] samp_idx,
    input  logic                   line,
    input  logic                   prev_bit,
    output logic                   bit_val
);
    localparam int IW    = $clog2(OSR);
    localparam int WIN_W = OSR / 2;
    localparam int CW    = $clog2(WIN_W + 1);
    localparam logic [IW-1:0] WIN_LO = IW'(OSR / 4);
    localparam logic [IW-1:0] WIN_HI = IW'(OSR / 4 + WIN_W);
    localparam logic [CW-1:0] HALF   = CW'(WIN_W / 2);
    localparam logic [CW-1:0] FULL   = CW'(WIN_W);

    logic          in_win;
    logic          hit;
    logic [CW-1:0] ones_q;
    logic [CW-1:0] total;

    // Decide whether this sample lies in the vote window, and form the running total.
    always_comb begin
        in_win = (samp_idx >= WIN_LO) && (samp_idx < WIN_HI);
        hit    = in_win & line;
        total  = ones_q + CW'(hit);
        if (total > HALF)      bit_val = 1'b1;
        else if (total < HALF) bit_val = 1'b0;
        else                   bit_val = prev_bit;
    end

    // Accumulate the ones inside the window; restart at each cell boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) ones_q <= '0;
        else if (hit)      ones_q <= ones_q + 1'b1;
    end

    p_win_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ones_q <= FULL);
endmodule

// File: rtl/nrz_frame_fsm.sv
// Character framing state machine.
// Hunts for a falling edge, steps through the cells of the start bit, the data
// bits and the stop bit, and returns to hunting right after the stop vote, so
// that the next falling edge sets the timing afresh. The outputs are registered.
module nrz_frame_fsm
    import nrzrx_pkg::*;
#(
    parameter int OSR    = 32,
    parameter int DATA_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   line,
    input  logic                   bit_val,
    output logic [$clog2(OSR)-1:0] samp_idx,
    output logic                   voter_clr,
    output logic                   last_bit,
    output logic                   byte_valid,
    output logic [DATA_W-1:0]      byte_data,
    output logic                   framing_error
);
    localparam int IW = $clog2(OSR);
    localparam int BW = $clog2(DATA_W);
    localparam logic [IW-1:0] LAST_IDX = IW'(OSR - 1);
    localparam logic [IW-1:0] DEC_IDX  = IW'(OSR / 4 + OSR / 2 - 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

    rx_state_e         state;
    logic              line_q;
    logic [BW-1:0]     bit_idx;
    logic [DATA_W-1:0] shreg;

    // Clear the vote count while hunting and at the last sample of each cell.
    always_comb voter_clr = (state == ST_HUNT) || (samp_idx == LAST_IDX);

    // Track the edge, the cell position, the bit order and the output strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_HUNT;
            line_q        <= 1'b1;
            samp_idx      <= '0;
            bit_idx       <= '0;
            shreg         <= '0;
            last_bit      <= 1'b1;
            byte_valid    <= 1'b0;
            byte_data     <= '0;
            framing_error <= 1'b0;
        end else begin
            line_q        <= line;
            byte_valid    <= 1'b0;
            framing_error <= 1'b0;
            if (state == ST_HUNT) begin
                samp_idx <= '0;
                if (line_q && !line) begin
                    state    <= ST_START;
                    samp_idx <= IW'(1);
                    last_bit <= 1'b1;
                end
            end else begin
                samp_idx <= (samp_idx == LAST_IDX) ? '0 : samp_idx + 1'b1;
                case (state)
                    ST_START: begin
                        if (samp_idx == DEC_IDX) begin
                            if (bit_val) state <= ST_HUNT;
                            else         last_bit <= 1'b0;
                        end else if (samp_idx == LAST_IDX) begin
                            state   <= ST_DATA;
                            bit_idx <= '0;
                        end
                    end
                    ST_DATA: begin
                        if (samp_idx == DEC_IDX) begin
                            shreg    <= {bit_val, shreg[DATA_W-1:1]};
                            last_bit <= bit_val;
                        end else if (samp_idx == LAST_IDX) begin
                            if (bit_idx == LAST_BIT) state <= ST_STOP;
                            else                     bit_idx <= bit_idx + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (samp_idx == DEC_IDX) begin
                            state <= ST_HUNT;
                            if (bit_val) begin
                                byte_valid <= 1'b1;
                                byte_data  <= shreg;
                            end else begin
                                framing_error <= 1'b1;
                            end
                        end
                    end
                    default: state <= ST_HUNT;
                endcase
            end
        end
    end

    p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);
    p_excl_strobes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_valid && framing_error));
    p_hunt_after_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid || framing_error) |-> (state == ST_HUNT));
    p_glitch_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && samp_idx == DEC_IDX && bit_val) |=> (state == ST_HUNT));
endmodule

// File: rtl/nrz_crc16_check.sv
// CRC-16 frame check.
// Folds each accepted byte into the accumulator LSB first, using the reflected
// polynomial. At frame_end it compares the accumulator, including any byte in
// the same cycle, with the good-frame residue, then restarts it.
module nrz_crc16_check #(
    parameter int          DATA_W  = 8,
    parameter logic [15:0] POLY_R  = 16'h8408,
    parameter logic [15:0] INIT    = 16'hFFFF,
    parameter logic [15:0] RESIDUE = 16'hF0B8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              frame_end,
    output logic              crc_ok
);
    logic [15:0] crc_q;
    logic [15:0] crc_nx;

    // Unrolled bit-serial update over one byte.
    always_comb begin
        crc_nx = crc_q;
        if (byte_valid) begin
            for (int i = 0; i < DATA_W; i++) begin
                if (crc_nx[0] ^ byte_data[i]) crc_nx = (crc_nx >> 1) ^ POLY_R;
                else                          crc_nx = crc_nx >> 1;
            end
        end
    end

    // Hold the accumulator and capture the verdict at each end of frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q  <= INIT;
            crc_ok <= 1'b0;
        end else if (frame_end) begin
            crc_ok <= (crc_nx == RESIDUE);
            crc_q  <= INIT;
        end else begin
            crc_q <= crc_nx;
        end
    end

    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (crc_q == INIT));
    p_ok_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(crc_ok));
endmodule

// File: rtl/nrz_char_rx.sv
// Oversampled NRZ character receiver, top level.
// Connects the framing machine, the bit voter and the CRC check. line_in is
// assumed to be already synchronous to clk, which runs at OSR times the bit rate.
module nrz_char_rx #(
    parameter int OSR    = 32,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_in,
    input  logic              frame_end,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_data,
    output logic              framing_error,
    output logic              crc_ok
);
    localparam int IW = $clog2(OSR);

    logic [IW-1:0] samp_idx;
    logic          voter_clr;
    logic          last_bit;
    logic          bit_val;

    nrz_frame_fsm #(.OSR(OSR), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .line(line_in), .bit_val(bit_val),
        .samp_idx(samp_idx), .voter_clr(voter_clr), .last_bit(last_bit),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .framing_error(framing_error)
    );

    nrz_bit_voter #(.OSR(OSR)) u_voter (
        .clk(clk), .rst_n(rst_n), .clr(voter_clr), .samp_idx(samp_idx),
        .line(line_in), .prev_bit(last_bit), .bit_val(bit_val)
    );

    nrz_crc16_check #(.DATA_W(DATA_W)) u_crc (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid),
        .byte_data(byte_data), .frame_end(frame_end), .crc_ok(crc_ok)
    );

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!byte_valid && !framing_error && !crc_ok));
endmodule

// File: tb/tb_nrz_char_rx.sv
module tb_nrz_char_rx;
    localparam int CLK_PERIOD = 10;
    localparam int OSR        = 16;
    localparam int WIN_LO     = OSR / 4;
    localparam int WIN_W      = OSR / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_in = 1'b1;
    logic       frame_end = 1'b0;
    logic       byte_valid;
    logic [7:0] byte_data;
    logic       framing_error;
    logic       crc_ok;

    int checks = 0;
    int bad = 0;
    int cyc = 0;
    int ferr_cnt = 0;
    int last_start = 0;
    logic [7:0] got_q[$];
    int         got_t[$];

    nrz_char_rx #(.OSR(OSR), .DATA_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .frame_end(frame_end),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .framing_error(framing_error), .crc_ok(crc_ok)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: capture strobes away from the active edge.
    always @(negedge clk) begin
        if (byte_valid) begin
            got_q.push_back(byte_data);
            got_t.push_back(cyc);
        end
        if (framing_error) ferr_cnt++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic v);
        @(negedge clk);
        line_in = v;
    endtask

    // mode 0 clean, 1 noisy (outside window inverted, 3 window samples inverted), 2 tie
    task automatic send_bit(input logic v, input int len, input int mode);
        for (int i = 0; i < len; i++) begin
            logic s;
            logic inw;
            inw = (i >= WIN_LO) && (i < WIN_LO + WIN_W);
            s = v;
            if (mode == 1) s = (!inw || i < WIN_LO + 3) ? ~v : v;
            if (mode == 2) s = (inw && i < WIN_LO + WIN_W / 2) ? 1'b1 : 1'b0;
            put(s);
        end
    endtask

    task automatic send_char(input logic [7:0] b, input logic stop_v, input int drift,
                             input logic [7:0] noisy, input logic [7:0] tie, input int gap);
        put(1'b0);
        last_start = cyc;
        send_bit(1'b0, OSR - 1, 0);
        for (int i = 0; i < 8; i++)
            send_bit(b[i], (i < 4) ? OSR + drift : OSR, tie[i] ? 2 : (noisy[i] ? 1 : 0));
        send_bit(stop_v, OSR, 0);
        send_bit(1'b1, gap, 0);
    endtask

    task automatic send_plain(input logic [7:0] b, input int gap);
        send_char(b, 1'b1, 0, 8'h00, 8'h00, gap);
    endtask

    task automatic pulse_eof();
        @(negedge clk);
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
    endtask

    function automatic logic [15:0] crc_ref(input logic [7:0] d[$]);
        logic [15:0] c;
        c = 16'hFFFF;
        foreach (d[k]) begin
            for (int i = 0; i < 8; i++) begin
                if (c[0] ^ d[k][i]) c = (c >> 1) ^ 16'h8408;
                else                c = c >> 1;
            end
        end
        return ~c;
    endfunction

    task automatic pop_chk(input string tag, input logic [7:0] exp);
        if (got_q.size() == 0) chk(tag, 32'hDEAD, {24'h0, exp});
        else                   chk(tag, {24'h0, got_q.pop_front()}, {24'h0, exp});
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 byte_valid in reset", {31'h0, byte_valid}, 0);
        chk("R1 framing_error in reset", {31'h0, framing_error}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 crc_ok after reset", {31'h0, crc_ok}, 0);
        chk("R1 byte_valid after reset", {31'h0, byte_valid}, 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_basic();
        int t0;
        got_q.delete(); got_t.delete();
        send_plain(8'hA5, 6);
        t0 = last_start;
        chk("R2 one byte", got_q.size(), 1);
        chk("R2 latency", got_t.size() > 0 ? got_t[0] : -1, t0 + 9 * OSR + 3 * OSR / 4);
        pop_chk("R2 data A5", 8'hA5);
        send_plain(8'h00, 6);  pop_chk("R2 data 00", 8'h00);
        send_plain(8'hFF, 6);  pop_chk("R2 data FF", 8'hFF);
        send_plain(8'h3C, 6);  pop_chk("R2 data 3C LSB first", 8'h3C);
    endtask

    task automatic t_vote();
        got_q.delete();
        send_char(8'h96, 1'b1, 0, 8'hFF, 8'h00, 6);
        pop_chk("R3 noisy 96", 8'h96);
        send_char(8'h4B, 1'b1, 0, 8'hFF, 8'h00, 6);
        pop_chk("R3 noisy 4B", 8'h4B);
    endtask

    task automatic t_tie();
        got_q.delete();
        send_char(8'h01, 1'b1, 0, 8'h00, 8'h06, 6);
        pop_chk("R4 tie follows previous one", 8'h07);
        send_char(8'hDE, 1'b1, 0, 8'h00, 8'h21, 6);
        pop_chk("R4 tie bit0 takes start zero", 8'hFE);
    endtask

    task automatic t_glitch();
        int f0;
        got_q.delete();
        f0 = ferr_cnt;
        repeat (3) put(1'b0);
        repeat (40) put(1'b1);
        chk("R5 glitch no byte", got_q.size(), 0);
        chk("R5 glitch no framing error", ferr_cnt - f0, 0);
        send_plain(8'h5A, 6);
        pop_chk("R5 receive after glitch", 8'h5A);
    endtask

    task automatic t_ferr();
        int f0;
        got_q.delete();
        f0 = ferr_cnt;
        send_char(8'h81, 1'b0, 0, 8'h00, 8'h00, 0);
        send_bit(1'b1, 40, 0);
        chk("R6 framing error pulse", ferr_cnt - f0, 1);
        chk("R6 no byte on bad stop", got_q.size(), 0);
    endtask

    task automatic t_drift();
        got_q.delete();
        send_char(8'hC3, 1'b1, 1, 8'h00, 8'h00, 0);
        send_char(8'h69, 1'b1, 1, 8'h00, 8'h00, 0);
        send_char(8'h17, 1'b1, 1, 8'h00, 8'h00, 0);
        send_char(8'hE8, 1'b1, -1, 8'h00, 8'h00, 0);
        send_char(8'h55, 1'b1, -1, 8'h00, 8'h00, 0);
        send_char(8'hAA, 1'b1, -1, 8'h00, 8'h00, 8);
        pop_chk("R7 slow C3", 8'hC3);
        pop_chk("R7 slow 69", 8'h69);
        pop_chk("R7 slow 17", 8'h17);
        pop_chk("R7 fast E8", 8'hE8);
        pop_chk("R7 fast 55", 8'h55);
        pop_chk("R7 fast AA", 8'hAA);
    endtask

    task automatic t_crc();
        logic [7:0]  pl[$];
        logic [15:0] c;
        pl = '{8'h31, 8'h32, 8'h33, 8'h34};
        c = crc_ref(pl);
        pulse_eof();
        foreach (pl[k]) send_plain(pl[k], 4);
        send_plain(c[7:0], 4);
        send_plain(c[15:8], 4);
        chk("R9 crc_ok unchanged before frame_end", {31'h0, crc_ok}, 0);
        pulse_eof();
        chk("R8 good frame", {31'h0, crc_ok}, 1);
        repeat (20) @(negedge clk);
        chk("R9 crc_ok held", {31'h0, crc_ok}, 1);
        send_plain(8'h31, 4); send_plain(8'h32, 4);
        send_plain(8'h37, 4); send_plain(8'h34, 4);
        send_plain(c[7:0], 4); send_plain(c[15:8], 4);
        pulse_eof();
        chk("R8 corrupted frame", {31'h0, crc_ok}, 0);
        send_plain(8'h31, 4); send_plain(8'h32, 4);
        send_char(8'h99, 1'b0, 0, 8'h00, 8'h00, 0);
        send_bit(1'b1, 30, 0);
        send_plain(8'h33, 4); send_plain(8'h34, 4);
        send_plain(c[7:0], 4); send_plain(c[15:8], 4);
        pulse_eof();
        chk("R6 framed-out byte not in CRC", {31'h0, crc_ok}, 1);
        got_q.delete();
    endtask

    initial begin
        t_reset();
        t_basic();
        t_vote();
        t_tie();
        t_glitch();
        t_ferr();
        t_drift();
        t_crc();
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule